// File: doc/BRIEF.md
# Multi-Rail Power Sequencer Supervisor

This controller powers up a panel supply in a fixed order and then watches it for faults. A cycle counter stands in for the charge and discharge ramps of an external timing capacitor. A bring-up takes six ramps. Each ramp has a fast phase of `FAST_CYC` cycles and then a slow phase of `SLOW_CYC` cycles, and each ramp ends in a peak. Rail enables switch on at particular peaks. At particular ramps, checks decide whether the sequence goes on or the chip latches off.

Once the sixth ramp has verified every rail, the block enters a monitoring state. Two kinds of fault are handled there:
- **Critical faults** shut the rails down at once. These are a stuck timing pin, a lost reference and over-temperature.
- **Rail faults** start a retry timer. The chip latches off only if the fault lasts for `FLT_CYC` consecutive cycles.

A latched fault is cleared only by dropping the enable or the input supply. All inputs are asynchronous and each passes through a two-flop synchronizer.

Top module: `rail_seq_sup`

## Requirements
- R1: After reset, and whenever the block is idle, the outputs are as follows:
  - `logic_en`, `ref_en`, `boost_en`, `neg_en`, `pos_en`, `fault` and `done` are 0.
  - The active-low outputs `pg_n` and `dsw_n` are 1.
- R2: Bring-up starts when the synchronized `en` and `vin_ok` are both high and `dly_lo` is low. The state changes on the third rising edge after the inputs change, and `logic_en` rises on that edge. While `dly_lo` is high the block stays idle.
- R3: Each ramp lasts `FAST_CYC`+`SLOW_CYC` cycles, and `ref_en` rises at the first peak. If `ot_flag` is seen during the slow phase of the first ramp, the block latches a fault.
- R4: Throughout the second ramp, `ref_ok` low or `ot_flag` high latches a fault. At the second peak `pg_n` goes low and `boost_en` rises.
- R5: `neg_en` rises at the fourth peak. At the fifth peak `dsw_n` goes low and `pos_en` rises.
- R6: At the sixth peak the block checks the `rail_flt` bits. If all are clear, `done` rises and monitoring begins. If any bit is set, the block latches a fault instead.
- R7: While monitoring, any of `dly_hi`, `dly_lo`, `ref_ok` low or `ot_flag` latches a fault within three edges. On a latched fault:
  - `fault` is 1.
  - `boost_en`, `neg_en` and `pos_en` are 0, and `pg_n`, `dsw_n` are 1.
  - `done` is 0.
  - `ref_en` and `logic_en` keep their values.
- R8: While monitoring, the block latches a fault if any `rail_flt` bit stays set for `FLT_CYC` consecutive synchronized cycles. A shorter fault resets the timer and leaves `done` set.
- R9: A latched fault persists until the synchronized `en` or `vin_ok` goes low. The block then returns to the idle state of R1, with the latch cleared, three edges after the input change.
- R10: While `dly_hi` is high at the first peak, the sequence stalls there with `ref_en` low. Once `dly_hi` drops, the first peak completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input supply above its start threshold |
| en | input | 1 | Chip enable |
| ref_ok | input | 1 | Reference voltage within range |
| ot_flag | input | 1 | Over-temperature |
| rail_flt | input | NRAIL | Per-rail fault comparators: boost, power-good, negative, delayed switch, positive |
| dly_hi | input | 1 | Timing pin stuck high |
| dly_lo | input | 1 | Timing pin stuck low |
| logic_en | output | 1 | Reference and logic supply bias enable |
| ref_en | output | 1 | Reference output enable |
| pg_n | output | 1 | Input protection switch drive, active low |
| boost_en | output | 1 | Boost soft-start enable |
| neg_en | output | 1 | Negative rail enable |
| dsw_n | output | 1 | Delayed-output switch drive, active low |
| pos_en | output | 1 | Positive rail enable |
| fault | output | 1 | Latched shutdown flag |
| done | output | 1 | Sequence complete, monitoring active |

## Verification
A clean bring-up is compared at both sides of every peak, so an enable that moves to the wrong ramp shows up as an early or late edge. A check fails at each ramp in turn:
- over-temperature in the first ramp,
- a lost reference in the second ramp,
- a rail fault present at the sixth peak.

Each of these pins down which output vector the latch freezes, including whether `ref_en` was already on. In monitoring, a rail fault shorter than the retry window is set against one that outlasts it, which separates a timer that clears from one that only saturates. An over-temperature event shows that critical faults bypass the timer. Stuck-low and stuck-high timing pins, and release of the latch through enable or supply removal, cover the start and stall gating.

// File: rtl/rail_seq_sup.sv
module rail_seq_sup #(
  parameter int FAST_CYC = 64,
  parameter int SLOW_CYC = 192,
  parameter int FLT_CYC  = 1024,
  parameter int NRAIL    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin_ok,
  input  logic             en,
  input  logic             ref_ok,
  input  logic             ot_flag,
  input  logic [NRAIL-1:0] rail_flt,
  input  logic             dly_hi,
  input  logic             dly_lo,
  output logic             logic_en,
  output logic             ref_en,
  output logic             pg_n,
  output logic             boost_en,
  output logic             neg_en,
  output logic             dsw_n,
  output logic             pos_en,
  output logic             fault,
  output logic             done
);
  localparam int RAMP_CYC = FAST_CYC + SLOW_CYC;
  localparam int CW       = $clog2(RAMP_CYC + 1);
  localparam int TW       = $clog2(FLT_CYC + 1);
  localparam int NIN      = NRAIL + 6;
  localparam logic [CW-1:0] CNT_LAST = CW'(RAMP_CYC - 1);
  localparam logic [CW-1:0] CNT_SLOW = CW'(FAST_CYC);
  localparam logic [TW-1:0] TMR_LAST = TW'(FLT_CYC - 1);

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_MON, S_LATCH} st_t;

  logic [NIN-1:0] sy1, sy2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {dly_lo, dly_hi, ot_flag, ref_ok, en, vin_ok, rail_flt};
      sy2 <= sy1;
    end

  logic [NRAIL-1:0] s_rail;
  logic s_vin, s_en, s_ref, s_ot, s_dhi, s_dlo;
  assign s_rail = sy2[NRAIL-1:0];
  assign s_vin  = sy2[NRAIL];
  assign s_en   = sy2[NRAIL+1];
  assign s_ref  = sy2[NRAIL+2];
  assign s_ot   = sy2[NRAIL+3];
  assign s_dhi  = sy2[NRAIL+4];
  assign s_dlo  = sy2[NRAIL+5];

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    ramp;
  logic [TW-1:0] tmr;

  logic go, crit, rail_bad, last, slow, trip;
  assign go       = s_en & s_vin;
  assign crit     = s_dhi | s_dlo | ~s_ref | s_ot;
  assign rail_bad = |s_rail;
  assign last     = (cnt == CNT_LAST);
  assign slow     = (cnt >= CNT_SLOW);

  always_comb begin
    trip = 1'b0;
    case (st)
      S_RAMP: trip = (ramp == 3'd1 && slow && s_ot) ||
                     (ramp == 3'd2 && (!s_ref || s_ot)) ||
                     (ramp == 3'd6 && last && rail_bad);
      S_MON:  trip = crit || (rail_bad && tmr == TMR_LAST);
      default: trip = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OFF; cnt <= '0; ramp <= 3'd1; tmr <= '0;
      logic_en <= 1'b0; ref_en <= 1'b0; pg_n <= 1'b1; boost_en <= 1'b0;
      neg_en <= 1'b0; dsw_n <= 1'b1; pos_en <= 1'b0; fault <= 1'b0; done <= 1'b0;
    end else if (!go) begin
      st <= S_OFF; cnt <= '0; ramp <= 3'd1; tmr <= '0;
      logic_en <= 1'b0; ref_en <= 1'b0; pg_n <= 1'b1; boost_en <= 1'b0;
      neg_en <= 1'b0; dsw_n <= 1'b1; pos_en <= 1'b0; fault <= 1'b0; done <= 1'b0;
    end else if (trip) begin
      st <= S_LATCH; fault <= 1'b1; tmr <= '0;
      boost_en <= 1'b0; neg_en <= 1'b0; pos_en <= 1'b0;
      pg_n <= 1'b1; dsw_n <= 1'b1; done <= 1'b0;
    end else begin
      case (st)
        S_OFF:
          if (!s_dlo) begin
            st <= S_RAMP; logic_en <= 1'b1; cnt <= '0; ramp <= 3'd1;
          end
        S_RAMP:
          if (!last) cnt <= cnt + 1'b1;
          else if (!(ramp == 3'd1 && s_dhi)) begin
            cnt  <= '0;
            ramp <= ramp + 3'd1;
            case (ramp)
              3'd1: ref_en <= 1'b1;
              3'd2: begin pg_n <= 1'b0; boost_en <= 1'b1; end
              3'd4: neg_en <= 1'b1;
              3'd5: begin dsw_n <= 1'b0; pos_en <= 1'b1; end
              3'd6: begin st <= S_MON; done <= 1'b1; end
              default: ;
            endcase
          end
        S_MON:
          tmr <= rail_bad ? tmr + 1'b1 : '0;
        default: ;
      endcase
    end
endmodule

module rail_seq_sup_chk #(
  parameter int TW      = 4,
  parameter int FLT_CYC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_en,
  input logic          s_vin,
  input logic [TW-1:0] tmr,
  input logic          logic_en,
  input logic          ref_en,
  input logic          pg_n,
  input logic          boost_en,
  input logic          neg_en,
  input logic          dsw_n,
  input logic          pos_en,
  input logic          fault,
  input logic          done
);
  AST_LATCH_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!boost_en && !neg_en && !pos_en && pg_n && dsw_n && !done)); // R7
  AST_DONE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (boost_en && neg_en && pos_en && !pg_n && !dsw_n && ref_en && !fault)); // R6
  AST_POS_AFTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    pos_en |-> (neg_en && boost_en)); // R5
  AST_PG_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n |-> ref_en); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && s_en && s_vin) |=> fault); // R9
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> (!fault && !logic_en && !ref_en)); // R9
  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr < TW'(FLT_CYC)); // R8
endmodule

bind rail_seq_sup rail_seq_sup_chk #(.TW(TW), .FLT_CYC(FLT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_en(s_en), .s_vin(s_vin), .tmr(tmr),
  .logic_en(logic_en), .ref_en(ref_en), .pg_n(pg_n), .boost_en(boost_en),
  .neg_en(neg_en), .dsw_n(dsw_n), .pos_en(pos_en), .fault(fault), .done(done)
);

// File: tb/rail_seq_sup_tb.sv
module rail_seq_sup_tb;
  localparam int NR = 5;
  // vector order: {done, fault, pos_en, dsw_n, neg_en, boost_en, pg_n, ref_en, logic_en}
  localparam logic [8:0] V_OFF  = 9'b000100100;
  localparam logic [8:0] V_LOG  = 9'b000100101;
  localparam logic [8:0] V_REF  = 9'b000100111;
  localparam logic [8:0] V_BST  = 9'b000101011;
  localparam logic [8:0] V_NEG  = 9'b000111011;
  localparam logic [8:0] V_POS  = 9'b001011011;
  localparam logic [8:0] V_DONE = 9'b101011011;
  localparam logic [8:0] V_LAT  = 9'b010100111;
  localparam logic [8:0] V_LAT0 = 9'b010100101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vin_ok = 1'b1, en = 1'b0, ref_ok = 1'b1, ot_flag = 1'b0;
  logic dly_hi = 1'b0, dly_lo = 1'b0;
  logic [NR-1:0] rail_flt = '0;
  logic logic_en, ref_en, pg_n, boost_en, neg_en, dsw_n, pos_en, fault, done;
  logic [8:0] obs;
  assign obs = {done, fault, pos_en, dsw_n, neg_en, boost_en, pg_n, ref_en, logic_en};

  always #10 clk = ~clk;

  rail_seq_sup #(.FAST_CYC(4), .SLOW_CYC(6), .FLT_CYC(20), .NRAIL(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .en(en), .ref_ok(ref_ok),
    .ot_flag(ot_flag), .rail_flt(rail_flt), .dly_hi(dly_hi), .dly_lo(dly_lo),
    .logic_en(logic_en), .ref_en(ref_en), .pg_n(pg_n), .boost_en(boost_en),
    .neg_en(neg_en), .dsw_n(dsw_n), .pos_en(pos_en), .fault(fault), .done(done));

  typedef struct { int c; logic [8:0] v; string tag; } item_t;
  item_t q[$];
  int cyc = 0, base = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (q.size() > 0 && q[0].c == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (obs !== it.v) begin
        errors++;
        $display("FAIL %s at cycle %0d: got %b expected %b", it.tag, cyc, obs, it.v);
      end
    end

  task automatic mark(); base = cyc; endtask
  task automatic push(int k, logic [8:0] v, string tag);
    item_t it;
    it.c = base + k; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask
  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bringup();
    @(negedge clk); en = 1'b1; dly_lo = 1'b0; mark();
    push(2, V_OFF, "R2"); push(3, V_LOG, "R2");
    push(12, V_LOG, "R3"); push(13, V_REF, "R3");
    push(22, V_REF, "R4"); push(23, V_BST, "R4");
    push(42, V_BST, "R5"); push(43, V_NEG, "R5");
    push(52, V_NEG, "R5"); push(53, V_POS, "R5");
    push(62, V_POS, "R6"); push(63, V_DONE, "R6");
    drain();
  endtask

  task automatic en_off();
    @(negedge clk); en = 1'b0; mark();
    push(3, V_OFF, "R9");
    drain();
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (obs !== V_OFF) begin
      errors++;
      $display("FAIL R1 reset: got %b expected %b", obs, V_OFF);
    end
    rst_n = 1'b1;
    @(negedge clk); mark(); push(2, V_OFF, "R1"); drain();

    bringup();

    // R8 short rail fault clears
    @(negedge clk); rail_flt[2] = 1'b1; mark();
    push(30, V_DONE, "R8");
    repeat (10) @(negedge clk);
    rail_flt[2] = 1'b0;
    drain();
    // R8 long rail fault latches
    @(negedge clk); rail_flt[0] = 1'b1; mark();
    push(21, V_DONE, "R8"); push(22, V_LAT, "R8"); push(40, V_LAT, "R9");
    drain();
    @(negedge clk); rail_flt[0] = 1'b0; mark(); push(6, V_LAT, "R9"); drain();
    @(negedge clk); en = 1'b0; mark();
    push(2, V_LAT, "R9"); push(3, V_OFF, "R9");
    drain();

    // R7 critical fault in monitoring
    bringup();
    @(negedge clk); ot_flag = 1'b1; mark();
    push(2, V_DONE, "R7"); push(3, V_LAT, "R7");
    drain();
    ot_flag = 1'b0;
    en_off();

    // R2 stuck-low timing pin blocks start
    @(negedge clk); dly_lo = 1'b1; en = 1'b1; mark();
    push(3, V_OFF, "R2"); push(25, V_OFF, "R2");
    drain();
    bringup();

    // R9 supply removal clears latch
    @(negedge clk); rail_flt[4] = 1'b1; mark(); push(22, V_LAT, "R8"); drain();
    @(negedge clk); vin_ok = 1'b0; rail_flt[4] = 1'b0; mark();
    push(2, V_LAT, "R9"); push(3, V_OFF, "R9");
    drain();
    @(negedge clk); en = 1'b0; vin_ok = 1'b1;
    repeat (5) @(negedge clk);

    // R10 stuck-high pin stalls at first peak
    @(negedge clk); dly_hi = 1'b1; en = 1'b1; mark();
    push(13, V_LOG, "R10"); push(40, V_LOG, "R10");
    drain();
    @(negedge clk); dly_hi = 1'b0; mark();
    push(2, V_LOG, "R10"); push(3, V_REF, "R10");
    drain();
    en_off();

    // R4 reference lost during second ramp
    ref_ok = 1'b0;
    @(negedge clk); en = 1'b1; mark();
    push(13, V_REF, "R4"); push(14, V_LAT, "R4");
    drain();
    ref_ok = 1'b1;
    en_off();

    // R3 over-temperature in first ramp slow phase
    ot_flag = 1'b1;
    @(negedge clk); en = 1'b1; mark();
    push(7, V_LOG, "R3"); push(8, V_LAT0, "R3");
    drain();
    ot_flag = 1'b0;
    en_off();

    // R6 rail fault present at the sixth peak
    rail_flt[1] = 1'b1;
    @(negedge clk); en = 1'b1; mark();
    push(62, V_POS, "R6"); push(63, V_LAT, "R6");
    drain();
    rail_flt[1] = 1'b0;
    en_off();

    finish_up();
  end
endmodule